// File: doc/BRIEF.md
# Frame Task Sequencer

A control block for one antenna node of a distributed multi-antenna base station. The node owns one shared arithmetic engine, and this sequencer decides what that engine works on next. It follows a repeating time-division OFDM frame, advancing one symbol position per `sym_tick` pulse. It issues one task at a time as an opcode, a symbol index and a start pulse, and it waits for the engine's done pulse before it issues the next task.

The work order is set by deadlines rather than by arrival. When the pilot arrives, the channel-estimation chain runs first. In zero-forcing mode the block then stalls until the central inverse matrix has been delivered. Once the weight vector exists, a configurable number of waiting uplink symbols go first. Then every downlink symbol is processed back to back, ahead of its transmit slot. Uplink symbols that arrive meanwhile wait in a counted queue and fill the idle gaps, including the wait for the next inverse. Two sticky flags report a queue overflow and a downlink result that was not ready when its slot began.

Top module: `frame_task_seq`

## Requirements
- R1: After reset `frame_pos` is 0. Each `sym_tick` advances it by one. After position U1+U2+D+2 it returns to 0, so a frame lasts U1+U2+D+3 ticks. Here U1=`cfg_ul_pre`, U2=`cfg_ul_post` and D=`cfg_dl_cnt`. Positions 0..U1-1 are uplink, U1 is the pilot, U1+1..U1+U2 are uplink, U1+U2+1 is a guard, the next D positions are downlink slots, and the last position is a guard.
- R2: The four count inputs and the early-uplink count are captured only at the tick that wraps the frame (and once just after reset). A change in the middle of a frame does not alter that frame's length.
- R3: The tick that ends the pilot position starts a chain. In zero-forcing mode (`cfg_cb_mode`=0) the chain issues opcodes 1 (pilot FFT), 2 (channel estimate) and 3 (Gram contribution) in that order. Opcode 4 (weight vector) is issued only after an `inv_ready` pulse.
- R4: In conjugate-beamforming mode (`cfg_cb_mode`=1) the chain issues opcodes 1 and 2 only. Downlink work then follows with no opcode 3 or 4, and no `inv_ready` is needed.
- R5: After the weight vector (or after opcode 2 in conjugate mode), up to `cfg_ul_early` queued uplink symbols are issued as opcode 5. Then all D downlink symbols are issued as opcode 6, with `task_sym` = 0,1,..,D-1 in order.
- R6: Every uplink symbol received (the tick that ends an uplink position) is queued. Queued symbols are issued as opcode 5 when nothing of higher priority is ready, including while the block waits for the inverse. `task_sym` is the running count of uplink tasks issued since reset, starting at 0.
- R7: `task_start` is a one-cycle pulse, and `task_op`/`task_sym` hold their values until `task_done`. No new start occurs before the outstanding task's `task_done`.
- R8: If an uplink symbol arrives while the queue already holds BUF_DEPTH symbols, the symbol is dropped and `ul_overflow` goes to 1 and stays there until reset.
- R9: If, at the tick that starts downlink slot j, fewer than j+1 downlink tasks of this frame have completed, `dl_miss` goes to 1 and stays there until reset.
- R10: During and right after reset, `task_op` is 0 (none), `task_start` is 0, `frame_pos` is 0 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_tick | input | 1 | One-cycle pulse at the end of each symbol period |
| cfg_ul_pre | input | SYM_W | Uplink symbols before the pilot |
| cfg_ul_post | input | SYM_W | Uplink symbols after the pilot |
| cfg_dl_cnt | input | SYM_W | Downlink symbols per frame |
| cfg_ul_early | input | SYM_W | Uplink symbols served before downlink work |
| cfg_cb_mode | input | 1 | 1 = conjugate beamforming, 0 = zero forcing |
| inv_ready | input | 1 | Pulse: the central inverse has arrived |
| task_done | input | 1 | Pulse: the engine finished the current task |
| task_op | output | 3 | Current task opcode |
| task_sym | output | SYM_W | Symbol index of the current task |
| task_start | output | 1 | One-cycle start pulse for a new task |
| frame_pos | output | SYM_W+2 | Current symbol position in the frame |
| ul_overflow | output | 1 | Sticky uplink queue overflow |
| dl_miss | output | 1 | Sticky downlink deadline miss |

## Verification
A wrong phase or counter state shows up at the ports on the very next issued task: an opcode out of order, a missing weight-vector step, or a gap in the uplink index sequence. The bench therefore logs every start with its opcode and index and compares the whole sequence for each frame. A frame-position error moves `frame_pos` within one tick and shifts the wrap point, which is checked exactly. Queue and deadline state errors reach the sticky flags at the one tick where the threshold is crossed, so the flags are sampled just before and just after that tick.

// File: rtl/fts_pkg.sv
package fts_pkg;
   typedef enum logic [2:0] {
      OP_NONE      = 3'd0,
      OP_PILOT_FFT = 3'd1,
      OP_CHEST     = 3'd2,
      OP_GRAM      = 3'd3,
      OP_VECTOR    = 3'd4,
      OP_UL        = 3'd5,
      OP_DL        = 3'd6
   } op_e;

   typedef enum logic [1:0] {
      SEG_UL,
      SEG_PILOT,
      SEG_GUARD,
      SEG_DL
   } seg_e;

   typedef enum logic [2:0] {
      PH_FILL,
      PH_CHEST,
      PH_GRAM,
      PH_WAIT,
      PH_EARLY,
      PH_DL
   } phase_e;
endpackage

// File: rtl/fts_frame_pos.sv
module fts_frame_pos
   import fts_pkg::*;
#(
   parameter int SYM_W = 6,
   localparam int POS_W = SYM_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_tick,
   input  logic [SYM_W-1:0] cfg_ul_pre,
   input  logic [SYM_W-1:0] cfg_ul_post,
   input  logic [SYM_W-1:0] cfg_dl_cnt,
   input  logic [SYM_W-1:0] cfg_ul_early,
   output logic [POS_W-1:0] pos,
   output logic [SYM_W-1:0] lat_dl,
   output logic [SYM_W-1:0] lat_early,
   output logic             ul_rx,
   output logic             pilot_rx,
   output logic             dl_slot,
   output logic [SYM_W-1:0] dl_slot_idx
);
   logic             cfg_vld;
   logic [SYM_W-1:0] lat_pre, lat_post;
   logic [POS_W-1:0] pilot_at, guard_at, dl_base, last_at, nxt;
   logic             wrap;
   seg_e             seg;

   assign pilot_at = POS_W'(lat_pre);
   assign guard_at = POS_W'(lat_pre) + POS_W'(lat_post) + POS_W'(1);
   assign dl_base  = guard_at + POS_W'(1);
   assign last_at  = dl_base + POS_W'(lat_dl);

   always_comb begin
      if (pos < pilot_at)       seg = SEG_UL;
      else if (pos == pilot_at) seg = SEG_PILOT;
      else if (pos < guard_at)  seg = SEG_UL;
      else if (pos == guard_at) seg = SEG_GUARD;
      else if (pos < last_at)   seg = SEG_DL;
      else                      seg = SEG_GUARD;
   end

   assign wrap        = sym_tick && (pos == last_at);
   assign nxt         = (pos == last_at) ? '0 : pos + POS_W'(1);
   assign ul_rx       = sym_tick && (seg == SEG_UL);
   assign pilot_rx    = sym_tick && (seg == SEG_PILOT);
   assign dl_slot     = sym_tick && (nxt >= dl_base) && (nxt < last_at);
   assign dl_slot_idx = SYM_W'(nxt - dl_base);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_vld   <= 1'b0;
         lat_pre   <= '0;
         lat_post  <= '0;
         lat_dl    <= '0;
         lat_early <= '0;
      end else if (!cfg_vld || wrap) begin
         cfg_vld   <= 1'b1;
         lat_pre   <= cfg_ul_pre;
         lat_post  <= cfg_ul_post;
         lat_dl    <= cfg_dl_cnt;
         lat_early <= cfg_ul_early;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pos <= '0;
      else if (sym_tick) pos <= nxt;
   end

   // R1
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_vld |-> (pos <= last_at));
endmodule

// File: rtl/fts_ul_queue.sv
module fts_ul_queue #(
   parameter int BUF_DEPTH = 8,
   parameter int IDX_W     = 6,
   localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ul_rx,
   input  logic             take,
   output logic             nonempty,
   output logic [IDX_W-1:0] head_idx,
   output logic             ovf
);
   logic [CNT_W-1:0] pending;
   logic             full;

   assign full     = (pending == CNT_W'(BUF_DEPTH));
   assign nonempty = (pending != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending  <= '0;
         head_idx <= '0;
         ovf      <= 1'b0;
      end else begin
         if (take) head_idx <= head_idx + IDX_W'(1);
         if (ul_rx && !take) begin
            if (full) ovf <= 1'b1;
            else      pending <= pending + CNT_W'(1);
         end else if (take && !ul_rx) begin
            pending <= pending - CNT_W'(1);
         end
      end
   end

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pending <= CNT_W'(BUF_DEPTH));
   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   // R6
   take_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> nonempty);
endmodule

// File: rtl/fts_dl_mon.sv
module fts_dl_mon #(
   parameter int SYM_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pilot_rx,
   input  logic             dl_done,
   input  logic             dl_slot,
   input  logic [SYM_W-1:0] dl_slot_idx,
   output logic             miss
);
   logic [SYM_W:0] done_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_cnt <= '0;
         miss     <= 1'b0;
      end else begin
         if (pilot_rx)     done_cnt <= '0;
         else if (dl_done) done_cnt <= done_cnt + (SYM_W+1)'(1);
         if (dl_slot && (done_cnt <= {1'b0, dl_slot_idx})) miss <= 1'b1;
      end
   end

   // R9
   miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss |=> miss);
endmodule

// File: rtl/fts_sched.sv
module fts_sched
   import fts_pkg::*;
#(
   parameter int SYM_W     = 6,
   parameter int ENABLE_CB = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pilot_rx,
   input  logic             inv_ready,
   input  logic             cb_mode,
   input  logic [SYM_W-1:0] lat_dl,
   input  logic [SYM_W-1:0] lat_early,
   input  logic             ul_nonempty,
   input  logic [SYM_W-1:0] ul_head_idx,
   input  logic             task_done,
   output logic             take,
   output op_e              op_r,
   output logic [SYM_W-1:0] sym_r,
   output logic             start_r,
   output logic             dl_done
);
   phase_e           ph, ph_n;
   logic [SYM_W-1:0] pb_cnt, pb_n, dl_idx, dl_n;
   logic             busy, pilot_pend, inv_seen, cb_eff;
   logic             iss, clr_pilot, clr_inv;
   op_e              iss_op;
   logic [SYM_W-1:0] iss_sym;

   generate
      if (ENABLE_CB != 0) begin : g_cb
         assign cb_eff = cb_mode;
      end else begin : g_nocb
         assign cb_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      iss       = 1'b0;
      iss_op    = OP_NONE;
      iss_sym   = '0;
      ph_n      = ph;
      pb_n      = pb_cnt;
      dl_n      = dl_idx;
      clr_pilot = 1'b0;
      clr_inv   = 1'b0;
      if (!busy) begin
         case (ph)
            PH_FILL: begin
               if (pilot_pend) begin
                  iss       = 1'b1;
                  iss_op    = OP_PILOT_FFT;
                  clr_pilot = 1'b1;
                  ph_n      = PH_CHEST;
               end else if (ul_nonempty) begin
                  iss     = 1'b1;
                  iss_op  = OP_UL;
                  iss_sym = ul_head_idx;
               end
            end
            PH_CHEST: begin
               iss    = 1'b1;
               iss_op = OP_CHEST;
               pb_n   = '0;
               ph_n   = cb_eff ? PH_EARLY : PH_GRAM;
            end
            PH_GRAM: begin
               iss    = 1'b1;
               iss_op = OP_GRAM;
               ph_n   = PH_WAIT;
            end
            PH_WAIT: begin
               if (inv_seen) begin
                  iss     = 1'b1;
                  iss_op  = OP_VECTOR;
                  clr_inv = 1'b1;
                  pb_n    = '0;
                  ph_n    = PH_EARLY;
               end else if (ul_nonempty) begin
                  iss     = 1'b1;
                  iss_op  = OP_UL;
                  iss_sym = ul_head_idx;
               end
            end
            PH_EARLY: begin
               if ((pb_cnt < lat_early) && ul_nonempty) begin
                  iss     = 1'b1;
                  iss_op  = OP_UL;
                  iss_sym = ul_head_idx;
                  pb_n    = pb_cnt + SYM_W'(1);
               end else begin
                  dl_n = '0;
                  ph_n = PH_DL;
               end
            end
            PH_DL: begin
               if (dl_idx < lat_dl) begin
                  iss     = 1'b1;
                  iss_op  = OP_DL;
                  iss_sym = dl_idx;
                  dl_n    = dl_idx + SYM_W'(1);
               end else begin
                  ph_n = PH_FILL;
               end
            end
            default: ph_n = PH_FILL;
         endcase
      end
   end

   assign take    = iss && (iss_op == OP_UL);
   assign dl_done = busy && task_done && (op_r == OP_DL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph         <= PH_FILL;
         pb_cnt     <= '0;
         dl_idx     <= '0;
         busy       <= 1'b0;
         op_r       <= OP_NONE;
         sym_r      <= '0;
         start_r    <= 1'b0;
         pilot_pend <= 1'b0;
         inv_seen   <= 1'b0;
      end else begin
         ph      <= ph_n;
         pb_cnt  <= pb_n;
         dl_idx  <= dl_n;
         start_r <= iss;
         if (iss) begin
            busy  <= 1'b1;
            op_r  <= iss_op;
            sym_r <= iss_sym;
         end else if (busy && task_done) begin
            busy  <= 1'b0;
            op_r  <= OP_NONE;
            sym_r <= '0;
         end
         if (pilot_rx)       pilot_pend <= 1'b1;
         else if (clr_pilot) pilot_pend <= 1'b0;
         if (inv_ready)      inv_seen <= 1'b1;
         else if (clr_inv)   inv_seen <= 1'b0;
      end
   end

   // R7
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_r |=> !start_r);
   // R7
   no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !task_done) |=> !start_r);
   // R3
   vec_after_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_r && (op_r == OP_VECTOR)) |-> $past(inv_seen));
   // R4
   cb_skip_gram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_r && (op_r == OP_GRAM)) |-> !cb_eff);
endmodule

// File: rtl/frame_task_seq.sv
module frame_task_seq
   import fts_pkg::*;
#(
   parameter int SYM_W     = 6,
   parameter int BUF_DEPTH = 8,
   parameter int ENABLE_CB = 1,
   localparam int POS_W    = SYM_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_tick,
   input  logic [SYM_W-1:0] cfg_ul_pre,
   input  logic [SYM_W-1:0] cfg_ul_post,
   input  logic [SYM_W-1:0] cfg_dl_cnt,
   input  logic [SYM_W-1:0] cfg_ul_early,
   input  logic             cfg_cb_mode,
   input  logic             inv_ready,
   input  logic             task_done,
   output logic [2:0]       task_op,
   output logic [SYM_W-1:0] task_sym,
   output logic             task_start,
   output logic [POS_W-1:0] frame_pos,
   output logic             ul_overflow,
   output logic             dl_miss
);
   generate
      if (SYM_W < 2) begin : g_bad_sym
         $error("SYM_W must be at least 2");
      end
      if (BUF_DEPTH < 1) begin : g_bad_depth
         $error("BUF_DEPTH must be at least 1");
      end
   endgenerate

   logic [SYM_W-1:0] lat_dl, lat_early, dl_slot_idx, head_idx;
   logic             ul_rx, pilot_rx, dl_slot, take, nonempty, dl_done;
   op_e              op_r;

   fts_frame_pos #(.SYM_W(SYM_W)) u_pos (
      .clk         (clk),
      .rst_n       (rst_n),
      .sym_tick    (sym_tick),
      .cfg_ul_pre  (cfg_ul_pre),
      .cfg_ul_post (cfg_ul_post),
      .cfg_dl_cnt  (cfg_dl_cnt),
      .cfg_ul_early(cfg_ul_early),
      .pos         (frame_pos),
      .lat_dl      (lat_dl),
      .lat_early   (lat_early),
      .ul_rx       (ul_rx),
      .pilot_rx    (pilot_rx),
      .dl_slot     (dl_slot),
      .dl_slot_idx (dl_slot_idx)
   );

   fts_ul_queue #(.BUF_DEPTH(BUF_DEPTH), .IDX_W(SYM_W)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .ul_rx   (ul_rx),
      .take    (take),
      .nonempty(nonempty),
      .head_idx(head_idx),
      .ovf     (ul_overflow)
   );

   fts_sched #(.SYM_W(SYM_W), .ENABLE_CB(ENABLE_CB)) u_sched (
      .clk        (clk),
      .rst_n      (rst_n),
      .pilot_rx   (pilot_rx),
      .inv_ready  (inv_ready),
      .cb_mode    (cfg_cb_mode),
      .lat_dl     (lat_dl),
      .lat_early  (lat_early),
      .ul_nonempty(nonempty),
      .ul_head_idx(head_idx),
      .task_done  (task_done),
      .take       (take),
      .op_r       (op_r),
      .sym_r      (task_sym),
      .start_r    (task_start),
      .dl_done    (dl_done)
   );

   fts_dl_mon #(.SYM_W(SYM_W)) u_mon (
      .clk        (clk),
      .rst_n      (rst_n),
      .pilot_rx   (pilot_rx),
      .dl_done    (dl_done),
      .dl_slot    (dl_slot),
      .dl_slot_idx(dl_slot_idx),
      .miss       (dl_miss)
   );

   assign task_op = op_r;
endmodule

// File: tb/frame_task_seq_tb.sv
`timescale 1ns/1ps
module frame_task_seq_tb;
   localparam int SYM_W = 6;
   localparam int DEPTH = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sym_tick = 1'b0;
   logic [SYM_W-1:0] cfg_ul_pre = '0, cfg_ul_post = '0, cfg_dl_cnt = '0, cfg_ul_early = '0;
   logic             cfg_cb_mode = 1'b0;
   logic             inv_ready = 1'b0;
   logic             task_done = 1'b0;
   logic [2:0]       task_op;
   logic [SYM_W-1:0] task_sym;
   logic             task_start;
   logic [SYM_W+1:0] frame_pos;
   logic             ul_overflow, dl_miss;

   frame_task_seq #(.SYM_W(SYM_W), .BUF_DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick),
      .cfg_ul_pre(cfg_ul_pre), .cfg_ul_post(cfg_ul_post),
      .cfg_dl_cnt(cfg_dl_cnt), .cfg_ul_early(cfg_ul_early),
      .cfg_cb_mode(cfg_cb_mode), .inv_ready(inv_ready), .task_done(task_done),
      .task_op(task_op), .task_sym(task_sym), .task_start(task_start),
      .frame_pos(frame_pos), .ul_overflow(ul_overflow), .dl_miss(dl_miss)
   );

   always #10 clk = ~clk;

   int n_checks = 0, n_fail = 0;
   int tick_per = 60, tick_cnt = 0, tick_count = 0;
   bit tick_en = 0;
   int pe_lat = 2, pe_cnt = 0, inv_dly = 0, inv_cnt = 0;
   bit pe_en = 1, inv_en = 1, pe_busy = 0, inv_pend = 0, prev_start = 0;
   int cur_op = 0, hs_viol = 0, log_n = 0;
   int log_op[32], log_sym[32];

   // symbol tick generator
   always @(negedge clk) begin
      sym_tick = 1'b0;
      if (tick_en) begin
         if (tick_cnt == tick_per - 1) begin
            tick_cnt   = 0;
            sym_tick   = 1'b1;
            tick_count = tick_count + 1;
         end else begin
            tick_cnt = tick_cnt + 1;
         end
      end else begin
         tick_cnt = 0;
      end
   end

   // processing-element model, task log, inverse delivery
   always @(negedge clk) begin
      task_done = 1'b0;
      inv_ready = 1'b0;
      if (!rst_n) begin
         pe_busy  = 0;
         inv_pend = 0;
      end else begin
         if (task_start) begin
            if (pe_busy || prev_start) hs_viol = hs_viol + 1;
            if (log_n < 32) begin
               log_op[log_n]  = int'(task_op);
               log_sym[log_n] = int'(task_sym);
            end
            log_n   = log_n + 1;
            pe_busy = 1;
            pe_cnt  = pe_lat;
            cur_op  = int'(task_op);
         end else if (pe_busy && pe_en) begin
            if (pe_cnt == 0) begin
               task_done = 1'b1;
               pe_busy   = 0;
               if (cur_op == 3 && inv_en) begin
                  inv_pend = 1;
                  inv_cnt  = inv_dly;
               end
            end else begin
               pe_cnt = pe_cnt - 1;
            end
         end
         if (inv_pend) begin
            if (inv_cnt == 0) begin
               inv_ready = 1'b1;
               inv_pend  = 0;
            end else begin
               inv_cnt = inv_cnt - 1;
            end
         end
      end
      prev_start = task_start;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks = n_checks + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic expect_task(input string req, input int idx, input int op, input int sym);
      chk_eq({req, " op"}, log_op[idx], op);
      chk_eq({req, " sym"}, log_sym[idx], sym);
   endtask

   task automatic do_reset(input int u1, input int u2, input int d, input int early,
                           input bit cb, input int tper, input int lat,
                           input bit inv_on, input int idly, input bit pe_on);
      tick_en      = 0;
      rst_n        = 1'b0;
      cfg_ul_pre   = SYM_W'(u1);
      cfg_ul_post  = SYM_W'(u2);
      cfg_dl_cnt   = SYM_W'(d);
      cfg_ul_early = SYM_W'(early);
      cfg_cb_mode  = cb;
      tick_per     = tper;
      pe_lat       = lat;
      inv_en       = inv_on;
      inv_dly      = idly;
      pe_en        = pe_on;
      repeat (3) @(negedge clk);
      log_n      = 0;
      hs_viol    = 0;
      tick_count = 0;
      rst_n      = 1'b1;
      repeat (2) @(negedge clk);
      tick_en = 1;
   endtask

   task automatic wait_ticks(input int n);
      int target;
      target = tick_count + n;
      wait (tick_count == target);
      @(negedge clk);
   endtask

   // R10 reset state, R1 frame wrap, R2 mid-frame config ignored
   task automatic test_frame_pos();
      do_reset(2, 2, 2, 0, 0, 10, 1, 1, 2, 1);
      tick_en = 0;
      chk_eq("R10 task_op", int'(task_op), 0);
      chk_eq("R10 task_start", int'(task_start), 0);
      chk_eq("R10 frame_pos", int'(frame_pos), 0);
      chk_eq("R10 ul_overflow", int'(ul_overflow), 0);
      chk_eq("R10 dl_miss", int'(dl_miss), 0);
      tick_en = 1;
      wait_ticks(3);
      chk_eq("R1 pos after 3 ticks", int'(frame_pos), 3);
      cfg_dl_cnt = SYM_W'(5);
      wait_ticks(5);
      chk_eq("R2 pos 8 with old length", int'(frame_pos), 8);
      wait_ticks(1);
      chk_eq("R2 wrap at old length", int'(frame_pos), 0);
      wait_ticks(11);
      chk_eq("R1 pos 11 with new length", int'(frame_pos), 11);
      wait_ticks(1);
      chk_eq("R1 wrap at new length", int'(frame_pos), 0);
   endtask

   // R3, R5, R6, R7: zero forcing with a prompt inverse
   task automatic test_zf_order();
      do_reset(2, 2, 2, 1, 0, 60, 2, 1, 3, 1);
      wait_ticks(9);
      repeat (10) @(negedge clk);
      chk_eq("R5 zf task count", log_n, 10);
      expect_task("R6 ul0", 0, 5, 0);
      expect_task("R6 ul1", 1, 5, 1);
      expect_task("R3 pilot fft", 2, 1, 0);
      expect_task("R3 chest", 3, 2, 0);
      expect_task("R3 gram", 4, 3, 0);
      expect_task("R3 vector", 5, 4, 0);
      expect_task("R5 dl0", 6, 6, 0);
      expect_task("R5 dl1", 7, 6, 1);
      expect_task("R6 ul2", 8, 5, 2);
      expect_task("R6 ul3", 9, 5, 3);
      chk_eq("R7 handshake violations", hs_viol, 0);
      chk_eq("R9 no miss when on time", int'(dl_miss), 0);
      chk_eq("R8 no overflow", int'(ul_overflow), 0);
   endtask

   // R5: queued uplink served before downlink after the vector
   task automatic test_early_ul();
      do_reset(2, 2, 2, 1, 0, 120, 30, 1, 0, 1);
      wait_ticks(9);
      repeat (40) @(negedge clk);
      chk_eq("R5 early task count", log_n, 10);
      expect_task("R5 vector", 5, 4, 0);
      expect_task("R5 early ul2", 6, 5, 2);
      expect_task("R5 dl0 after early", 7, 6, 0);
      expect_task("R5 dl1 after early", 8, 6, 1);
      expect_task("R6 ul3 fill", 9, 5, 3);
      chk_eq("R9 no miss early", int'(dl_miss), 0);
      chk_eq("R7 handshake early", hs_viol, 0);
   endtask

   // R4: conjugate mode skips Gram and inverse wait
   task automatic test_cb_mode();
      do_reset(2, 2, 2, 0, 1, 60, 2, 0, 0, 1);
      wait_ticks(9);
      repeat (10) @(negedge clk);
      chk_eq("R4 cb task count", log_n, 8);
      expect_task("R4 pilot fft", 2, 1, 0);
      expect_task("R4 chest", 3, 2, 0);
      expect_task("R4 dl0 direct", 4, 6, 0);
      expect_task("R4 dl1 direct", 5, 6, 1);
      expect_task("R4 ul2", 6, 5, 2);
      chk_eq("R4 cb no miss", int'(dl_miss), 0);
   endtask

   // R3 stall, R6 fill while waiting, R9 deadline miss
   task automatic test_inverse_stall();
      do_reset(2, 2, 2, 0, 0, 60, 2, 0, 0, 1);
      wait_ticks(5);
      repeat (10) @(negedge clk);
      chk_eq("R9 miss clear before slot", int'(dl_miss), 0);
      chk_eq("R6 stall task count", log_n, 7);
      expect_task("R3 gram before wait", 4, 3, 0);
      expect_task("R6 ul2 during wait", 5, 5, 2);
      expect_task("R6 ul3 during wait", 6, 5, 3);
      wait_ticks(1);
      chk_eq("R9 miss at dl0 slot", int'(dl_miss), 1);
      wait_ticks(3);
      repeat (5) @(negedge clk);
      chk_eq("R9 miss sticky", int'(dl_miss), 1);
      chk_eq("R3 no vector without inverse", log_n, 7);
   endtask

   // R8 overflow with a stuck engine, R7 no second start
   task automatic test_overflow();
      do_reset(2, 2, 2, 0, 0, 20, 2, 1, 0, 0);
      wait_ticks(10);
      chk_eq("R8 queue full no overflow yet", int'(ul_overflow), 0);
      wait_ticks(1);
      chk_eq("R8 overflow raised", int'(ul_overflow), 1);
      wait_ticks(2);
      chk_eq("R8 overflow sticky", int'(ul_overflow), 1);
      chk_eq("R7 single start while busy", log_n, 1);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
   end

   initial begin
      test_frame_pos();
      test_zf_order();
      test_early_ul();
      test_cb_mode();
      test_inverse_stall();
      test_overflow();
      summary();
      $finish;
   end
endmodule